// File: doc/BRIEF.md
# DDR Burst Address Generator

This block produces the internal word address for a synchronous SRAM port that moves two data halves in every clock cycle, one on the rising edge and one on the falling edge. The external address bus is one bit narrower than the word index. The block supplies the missing least significant bit itself: it is 0 for the rising-edge half and 1 for the falling-edge half.

On a load command the block captures the external address as the base of a burst. Each continue command then steps the burst by two words, one clock cycle's worth. The step works on a two-bit position inside an aligned group of four words. The upper bits stay at the loaded value, so a second continue returns to the base word. For every cycle the block registers a rising-half word address and a falling-half word address, each with a valid flag, so that a downstream memory model can sample one address on each clock edge.

A cycle with the port deselected and no continue ends the burst. A continue that arrives while no burst is open produces no transfer.

Top module: `ddr_burst_addr_gen`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, both valid flags and both address outputs are 0 after that edge.
- R2: A load (`adv`=0, `sel`=1) sampled at a rising edge sets both valid flags after that edge, with `rise_addr` = {`ext_addr`, 0}.
- R3: Whenever the outputs are valid, bit 0 of `rise_addr` is 0, bit 0 of `fall_addr` is 1, and all other bits of the two addresses are equal.
- R4: A continue (`adv`=1) sampled while a burst is open adds 2 to bits [1:0] of the word address modulo 4. It never carries into the upper bits, and both valid flags stay set.
- R5: A load followed by one continue covers four distinct words. A second continue returns to the base word. For example, a base word of 2 gives the sequence 2,3 / 0,1 / 2,3.
- R6: During a continue, the values on `ext_addr` and `sel` have no effect on the outputs.
- R7: A deselect (`adv`=0, `sel`=0) clears both valid flags after the edge on which it is sampled, and both address outputs keep their last values.
- R8: A continue sampled while no burst is open (after reset or after a deselect) leaves both valid flags at 0 and both addresses unchanged.
- R9: A load sampled during an open burst discards the old burst position and restarts from the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Port select; with `adv` low, 1 loads and 0 deselects |
| adv | input | 1 | 1 continues the open burst; 0 loads or deselects |
| ext_addr | input | WORD_W-1 | External base address, lacking the lowest word bit |
| rise_addr | output | WORD_W | Word address for the rising-edge half |
| fall_addr | output | WORD_W | Word address for the falling-edge half |
| rise_vld | output | 1 | Rising-half address is valid |
| fall_vld | output | 1 | Falling-half address is valid |

## Verification
Every output comes from a single register stage. A command sampled at one rising edge is therefore visible on all four outputs right after that edge, and stays there until the next rising edge. The bench changes its inputs on falling edges and reads the outputs on the following falling edge, which gives every check exactly one clock of latency. In-line properties use the same single-cycle relation with `|=>`, comparing each output against the command and address sampled one edge earlier.

// File: rtl/ddr_bag_pkg.sv
package ddr_bag_pkg;

    typedef enum logic [1:0] {
        CMD_DESEL = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_CONT  = 2'd2
    } bag_cmd_e;

endpackage

// File: rtl/ddr_bag_cmd_decode.sv
module ddr_bag_cmd_decode
    import ddr_bag_pkg::*;
(
    input  logic     sel,
    input  logic     adv,
    input  logic     burst_open,
    output bag_cmd_e cmd
);

    always_comb begin
        if (adv) begin
            // a continue only counts when a burst is open
            cmd = burst_open ? CMD_CONT : CMD_DESEL;
        end else if (sel) begin
            cmd = CMD_LOAD;
        end else begin
            cmd = CMD_DESEL;
        end
    end

endmodule

// File: rtl/ddr_bag_pos_ctr.sv
module ddr_bag_pos_ctr
    import ddr_bag_pkg::*;
#(
    parameter int EXT_W = 19,
    parameter int CNT_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bag_cmd_e         cmd,
    input  logic [EXT_W-1:0] ext_addr,
    output logic [EXT_W-1:0] base_d,
    output logic [CNT_W-1:0] ofs_d,
    output logic             open_d,
    output logic             open_q
);

    typedef struct packed {
        logic [EXT_W-1:0] base;
        logic [CNT_W-1:0] ofs;
        logic             open;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (cmd)
            CMD_LOAD: begin
                st_d.base = ext_addr;
                st_d.ofs  = '0;
                st_d.open = 1'b1;
            end
            CMD_CONT: begin
                st_d.ofs  = st_q.ofs + CNT_W'(1);
            end
            default: begin
                st_d.open = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_d = st_d.base;
    assign ofs_d  = st_d.ofs;
    assign open_d = st_d.open;
    assign open_q = st_q.open;

endmodule

// File: rtl/ddr_bag_half_gen.sv
module ddr_bag_half_gen #(
    parameter int EXT_W = 19,
    parameter int CNT_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXT_W-1:0] base_d,
    input  logic [CNT_W-1:0] ofs_d,
    input  logic             open_d,
    output logic [EXT_W:0]   rise_addr,
    output logic [EXT_W:0]   fall_addr,
    output logic             rise_vld,
    output logic             fall_vld
);

    localparam int HALVES = 2;
    localparam int WORD_W = EXT_W + 1;

    typedef struct packed {
        logic [HALVES-1:0][WORD_W-1:0] addr;
        logic [HALVES-1:0]             vld;
    } half_t;

    half_t hf_d, hf_q;
    logic [EXT_W-1:0]              cyc_addr;
    logic [HALVES-1:0][WORD_W-1:0] word_addr;

    // position wraps inside the group; upper bits never change
    generate
        if (EXT_W > CNT_W) begin : g_upper
            assign cyc_addr = {base_d[EXT_W-1:CNT_W],
                               CNT_W'(base_d[CNT_W-1:0] + ofs_d)};
        end else begin : g_flat
            assign cyc_addr = EXT_W'(base_d + EXT_W'(ofs_d));
        end
        for (genvar h = 0; h < HALVES; h++) begin : g_half
            assign word_addr[h] = {cyc_addr, h[0]};
        end
    endgenerate

    always_comb begin
        hf_d = hf_q;
        for (int h = 0; h < HALVES; h++) begin
            hf_d.vld[h] = open_d;
            if (open_d) begin
                hf_d.addr[h] = word_addr[h];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hf_q <= '0;
        end else begin
            hf_q <= hf_d;
        end
    end

    assign rise_addr = hf_q.addr[0];
    assign fall_addr = hf_q.addr[1];
    assign rise_vld  = hf_q.vld[0];
    assign fall_vld  = hf_q.vld[1];

endmodule

// File: rtl/ddr_burst_addr_gen.sv
module ddr_burst_addr_gen
    import ddr_bag_pkg::*;
#(
    parameter int WORD_W = 20,
    parameter int POS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              adv,
    input  logic [WORD_W-2:0] ext_addr,
    output logic [WORD_W-1:0] rise_addr,
    output logic [WORD_W-1:0] fall_addr,
    output logic              rise_vld,
    output logic              fall_vld
);

    localparam int EXT_W = WORD_W - 1;
    localparam int CNT_W = POS_W - 1;
    localparam logic [POS_W-1:0] STEP = POS_W'(2);

    bag_cmd_e         cmd;
    logic [EXT_W-1:0] base_d;
    logic [CNT_W-1:0] ofs_d;
    logic             open_d;
    logic             open_q;

    ddr_bag_cmd_decode u_dec (
        .sel        (sel),
        .adv        (adv),
        .burst_open (open_q),
        .cmd        (cmd)
    );

    ddr_bag_pos_ctr #(.EXT_W(EXT_W), .CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .ext_addr (ext_addr),
        .base_d   (base_d),
        .ofs_d    (ofs_d),
        .open_d   (open_d),
        .open_q   (open_q)
    );

    ddr_bag_half_gen #(.EXT_W(EXT_W), .CNT_W(CNT_W)) u_half (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_d    (base_d),
        .ofs_d     (ofs_d),
        .open_d    (open_d),
        .rise_addr (rise_addr),
        .fall_addr (fall_addr),
        .rise_vld  (rise_vld),
        .fall_vld  (fall_vld)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!rise_vld && !fall_vld && rise_addr == '0 && fall_addr == '0));

    // R2
    load_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !adv) |=> (rise_vld && fall_vld && rise_addr == {$past(ext_addr), 1'b0}));

    // R4
    cont_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && rise_vld) |=> (rise_vld &&
            rise_addr[POS_W-1:0] == POS_W'($past(rise_addr[POS_W-1:0]) + STEP)));

    // R4
    cont_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && rise_vld) |=> (rise_addr[WORD_W-1:POS_W] == $past(rise_addr[WORD_W-1:POS_W])));

    // R7
    desel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && !adv) |=> (!rise_vld && !fall_vld && $stable(rise_addr)));

    // R8
    idle_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !rise_vld) |=> (!rise_vld && !fall_vld && $stable(fall_addr)));

endmodule

// File: tb/tb_ddr_burst_addr_gen.sv
module tb_ddr_burst_addr_gen;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 20;
    localparam int EXT_W      = WORD_W - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel = 1'b0;
    logic              adv = 1'b0;
    logic [EXT_W-1:0]  ext_addr = '0;
    logic [WORD_W-1:0] rise_addr, fall_addr;
    logic              rise_vld, fall_vld;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr_burst_addr_gen #(.WORD_W(WORD_W), .POS_W(2)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .adv       (adv),
        .ext_addr  (ext_addr),
        .rise_addr (rise_addr),
        .fall_addr (fall_addr),
        .rise_vld  (rise_vld),
        .fall_vld  (fall_vld)
    );

    // drive at a falling edge, then wait one full cycle for the registered result
    task automatic step(input logic s, input logic a, input logic [EXT_W-1:0] e);
        sel = s; adv = a; ext_addr = e;
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic ev,
                       input logic [WORD_W-1:0] er, input logic [WORD_W-1:0] ef);
        n_chk++;
        if (rise_vld !== ev || fall_vld !== ev || rise_addr !== er || fall_addr !== ef) begin
            n_err++;
            $display("FAIL %s: got vld=%b/%b rise=%h fall=%h, want vld=%b rise=%h fall=%h",
                     req, rise_vld, fall_vld, rise_addr, fall_addr, ev, er, ef);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(1'b1, 1'b0, 19'h00005);
        step(1'b1, 1'b0, 19'h00005);
        chk("R1 reset", 1'b0, 20'h0, 20'h0);
        rst_n = 1'b1;
        step(1'b0, 1'b1, 19'h00007);
        chk("R8 continue after reset", 1'b0, 20'h0, 20'h0);
    endtask

    task automatic t_wrap();
        step(1'b1, 1'b0, 19'h0ABC5);
        chk("R2 R3 load base", 1'b1, 20'h1578A, 20'h1578B);
        step(1'b0, 1'b1, 19'h7FFFF);
        chk("R4 R5 R6 first continue", 1'b1, 20'h15788, 20'h15789);
        step(1'b1, 1'b1, 19'h00000);
        chk("R5 R6 second continue wraps", 1'b1, 20'h1578A, 20'h1578B);
        step(1'b0, 1'b1, 19'h12345);
        chk("R4 third continue", 1'b1, 20'h15788, 20'h15789);
    endtask

    task automatic t_desel();
        step(1'b0, 1'b0, 19'h11111);
        chk("R7 deselect holds address", 1'b0, 20'h15788, 20'h15789);
        step(1'b1, 1'b1, 19'h22222);
        chk("R8 continue after deselect", 1'b0, 20'h15788, 20'h15789);
    endtask

    task automatic t_reload();
        step(1'b1, 1'b0, 19'h00003);
        chk("R2 R3 load low base", 1'b1, 20'h00006, 20'h00007);
        step(1'b0, 1'b1, 19'h00000);
        chk("R4 continue from 6", 1'b1, 20'h00004, 20'h00005);
        step(1'b1, 1'b0, 19'h7FFFF);
        chk("R9 reload mid burst", 1'b1, 20'hFFFFE, 20'hFFFFF);
        step(1'b0, 1'b1, 19'h00000);
        chk("R4 no carry into upper bits", 1'b1, 20'hFFFFC, 20'hFFFFD);
        step(1'b1, 1'b0, 19'h00000);
        chk("R9 R2 back-to-back load of zero", 1'b1, 20'h00000, 20'h00001);
        step(1'b0, 1'b1, 19'h7FFFF);
        chk("R5 R6 continue from zero", 1'b1, 20'h00002, 20'h00003);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_err++;
        $display("FAIL watchdog: got timeout, want completion");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_wrap();
        t_desel();
        t_reload();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule